// File: doc/BRIEF.md
# Soft-Start and Burst Supervisor

This block sequences a quasi-resonant switching regulator controller through its power-up and light-load phases. It watches comparator flags (supply above the turn-on level, supply below the selected turn-off level, feedback below the burst level, supply overvoltage, external fault, and supply below the protection release level) and a one-microsecond enable tick. From these it drives four outputs: an enable for the charge source, a step code for the soft-start current sink, a gate enable for the power switch driver, and a select that raises the supply turn-off threshold.

After reset the block sits in startup with the gate held off until the supply-on flag appears. Soft start then opens with a short charge pulse while the sink code walks down from its maximum one step per interval, which lets the feedback node rise in stairs. When the staircase ends the sink is off and the block runs normally. If feedback drops below the burst level once the burst check is armed, the gate is blocked and the turn-off threshold is raised, so the supply sags into a fresh startup. Overvoltage and fault events hold the gate off through a latch that clears only on the release flag.

Top module: `ss_burst_seq`

## Requirements
- R1: After reset the block is in startup: charge enable, sink code, gate enable and the high-threshold select are all 0.
- R2: Every flag passes through two flip-flops; a supply-on flag raised in startup moves the block to soft start on the third rising clock edge, and while the flag stays low the gate stays off.
- R3: On entry to soft start the charge enable is 1 and stays 1 for exactly CHARGE_US ticks, then goes to 0; clock cycles without a tick do not count.
- R4: The sink code is STEPS-1 on entry to soft start and drops by one after every STEP_US ticks.
- R5: After STEPS*STEP_US ticks soft start is over: the sink code is 0 and stays 0 while the gate enable remains 1.
- R6: The burst flag has no effect during the first CHARGE_US ticks of soft start; the gate enable stays 1.
- R7: Once armed (after the charge window, or in normal run), a synchronised burst flag blocks the gate and sets the high-threshold select to 1; both stay that way after the burst flag drops.
- R8: A synchronised supply-off flag in soft start, run or burst returns the block to startup with the select back at 0 (normal threshold); the next supply-on starts soft start again with the charge pulse and the sink code at STEPS-1.
- R9: A synchronised overvoltage or fault flag sets a protection latch that forces the gate enable to 0 and keeps it there after the flag drops.
- R10: The protection latch clears only when the synchronised release flag is 1; when set and release are present together the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle enable every microsecond |
| supply_on_i | input | 1 | Supply above turn-on level |
| supply_off_i | input | 1 | Supply below the selected turn-off level |
| fb_burst_i | input | 1 | Feedback below burst level |
| ovp_i | input | 1 | Supply overvoltage |
| fault_i | input | 1 | External fault comparator |
| release_i | input | 1 | Supply below protection release level |
| charge_en_o | output | 1 | Enable for the soft-start charge source |
| sink_code_o | output | CODE_W (3) | Soft-start sink step code, 0 = sink off |
| gate_en_o | output | 1 | Gate driver enable |
| off_high_o | output | 1 | 1 selects the high turn-off threshold |

## Verification
A phase register stuck in or skipping a state shows within three clock edges of the flag that should move it, as a gate enable or threshold select that disagrees with the expected phase. A wrong tick counter shows as a charge pulse of the wrong length or a sink code that changes one tick early or late at a step boundary, so the bench samples on both sides of each boundary. A protection latch that clears itself or ignores a set shows on the gate enable as soon as the triggering flag is removed.

// File: rtl/ss_burst_pkg.sv
package ss_burst_pkg;

  typedef enum logic [1:0] {
    PH_STARTUP = 2'd0,
    PH_SOFT    = 2'd1,
    PH_RUN     = 2'd2,
    PH_BURST   = 2'd3
  } phase_t;

  // flag vector positions
  localparam int FL_ON    = 0;
  localparam int FL_OFF   = 1;
  localparam int FL_BURST = 2;
  localparam int FL_OVP   = 3;
  localparam int FL_FAULT = 4;
  localparam int FL_REL   = 5;
  localparam int FL_NUM   = 6;

  // sink code for a staircase step index: highest code first
  function automatic int step_code(input int idx, input int steps);
    return steps - 1 - idx;
  endfunction

endpackage

// File: rtl/ss_flag_sync.sv
module ss_flag_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ss_stair_timer.sv
module ss_stair_timer
  import ss_burst_pkg::*;
#(
  parameter int CHARGE_US = 12,
  parameter int STEP_US   = 3000,
  parameter int STEPS     = 8,
  localparam int CODE_W   = $clog2(STEPS),
  localparam int CHG_W    = $clog2(CHARGE_US + 1),
  localparam int STEP_W   = $clog2(STEP_US)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  output logic              charge_on_o,
  output logic              armed_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);

  localparam logic [CHG_W-1:0]  CHG_MAX  = CHG_W'(CHARGE_US);
  localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(STEP_US - 1);
  localparam logic [CODE_W-1:0] IDX_MAX  = CODE_W'(STEPS - 1);

  logic [CHG_W-1:0]  chg_cnt_q;
  logic [STEP_W-1:0] step_cnt_q;
  logic [CODE_W-1:0] idx_q;
  logic              step_evt;

  assign step_evt = run_i && tick_i && (step_cnt_q == STEP_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_cnt_q <= '0;
    end else if (!run_i) begin
      chg_cnt_q <= '0;
    end else if (tick_i && chg_cnt_q != CHG_MAX) begin
      chg_cnt_q <= chg_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt_q <= '0;
      idx_q      <= '0;
    end else if (!run_i) begin
      step_cnt_q <= '0;
      idx_q      <= '0;
    end else if (tick_i) begin
      if (step_evt) begin
        step_cnt_q <= '0;
        if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
      end else begin
        step_cnt_q <= step_cnt_q + 1'b1;
      end
    end
  end

  assign charge_on_o = run_i && (chg_cnt_q != CHG_MAX);
  assign armed_o     = (chg_cnt_q == CHG_MAX);
  assign done_o      = step_evt && (idx_q == IDX_MAX);
  assign code_o      = run_i ? CODE_W'(step_code(int'(idx_q), STEPS)) : '0;

  // R4
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && idx_q != IDX_MAX) |=> (idx_q == $past(idx_q) + 1'b1));

  // R3
  charge_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(chg_cnt_q));

endmodule

// File: rtl/ss_prot_latch.sv
module ss_prot_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ovp_i,
  input  logic fault_i,
  input  logic release_i,
  output logic latched_o
);

  logic set_req;
  logic latched_q;

  assign set_req = ovp_i || fault_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latched_q <= 1'b0;
    else if (set_req)   latched_q <= 1'b1;
    else if (release_i) latched_q <= 1'b0;
  end

  assign latched_o = latched_q;

  // R9
  set_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> latched_q);

  // R10
  hold_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && !release_i) |=> latched_q);

endmodule

// File: rtl/ss_phase_fsm.sv
module ss_phase_fsm
  import ss_burst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   on_i,
  input  logic   off_i,
  input  logic   burst_i,
  input  logic   armed_i,
  input  logic   ss_done_i,
  output phase_t phase_o
);

  phase_t phase_q, phase_d;
  logic   burst_ok;

  assign burst_ok = burst_i && ((phase_q == PH_SOFT && armed_i) || phase_q == PH_RUN);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_STARTUP: if (on_i) phase_d = PH_SOFT;
      PH_SOFT: begin
        if (off_i)          phase_d = PH_STARTUP;
        else if (burst_ok)  phase_d = PH_BURST;
        else if (ss_done_i) phase_d = PH_RUN;
      end
      PH_RUN: begin
        if (off_i)         phase_d = PH_STARTUP;
        else if (burst_ok) phase_d = PH_BURST;
      end
      PH_BURST: if (off_i) phase_d = PH_STARTUP;
      default: phase_d = PH_STARTUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_STARTUP;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R8
  off_to_startup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_STARTUP && off_i) |=> (phase_q == PH_STARTUP));

  // R6
  no_early_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SOFT && !armed_i) |=> (phase_q != PH_BURST));

endmodule

// File: rtl/ss_burst_seq.sv
module ss_burst_seq
  import ss_burst_pkg::*;
#(
  parameter int CHARGE_US   = 12,
  parameter int STEP_US     = 3000,
  parameter int STEPS       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W     = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              supply_on_i,
  input  logic              supply_off_i,
  input  logic              fb_burst_i,
  input  logic              ovp_i,
  input  logic              fault_i,
  input  logic              release_i,
  output logic              charge_en_o,
  output logic [CODE_W-1:0] sink_code_o,
  output logic              gate_en_o,
  output logic              off_high_o
);

  logic [FL_NUM-1:0] flags_raw, flags_s;
  phase_t            phase;
  logic              ss_run, armed, ss_done, latched;

  assign flags_raw[FL_ON]    = supply_on_i;
  assign flags_raw[FL_OFF]   = supply_off_i;
  assign flags_raw[FL_BURST] = fb_burst_i;
  assign flags_raw[FL_OVP]   = ovp_i;
  assign flags_raw[FL_FAULT] = fault_i;
  assign flags_raw[FL_REL]   = release_i;

  ss_flag_sync #(.W(FL_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (flags_raw),
    .q_o   (flags_s)
  );

  ss_stair_timer #(.CHARGE_US(CHARGE_US), .STEP_US(STEP_US), .STEPS(STEPS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (ss_run),
    .tick_i      (tick_1us),
    .charge_on_o (charge_en_o),
    .armed_o     (armed),
    .code_o      (sink_code_o),
    .done_o      (ss_done)
  );

  ss_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_i      (flags_s[FL_ON]),
    .off_i     (flags_s[FL_OFF]),
    .burst_i   (flags_s[FL_BURST]),
    .armed_i   (armed),
    .ss_done_i (ss_done),
    .phase_o   (phase)
  );

  ss_prot_latch u_prot (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovp_i     (flags_s[FL_OVP]),
    .fault_i   (flags_s[FL_FAULT]),
    .release_i (flags_s[FL_REL]),
    .latched_o (latched)
  );

  assign ss_run     = (phase == PH_SOFT);
  assign gate_en_o  = (phase == PH_SOFT || phase == PH_RUN) && !latched;
  assign off_high_o = (phase == PH_BURST);

  // R7
  burst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_high_o |-> !gate_en_o);

  // R5
  run_sink_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |-> (sink_code_o == '0 && !charge_en_o));

  // R1
  startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STARTUP) |-> (!gate_en_o && !charge_en_o && !off_high_o));

endmodule

// File: tb/ss_burst_seq_tb.sv
module ss_burst_seq_tb;

  localparam int CLK_NS = 10;
  localparam int CHG    = 12;
  localparam int STEP   = 40;
  localparam int NSTEP  = 8;
  localparam int CW     = $clog2(NSTEP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic on_f = 1'b0, off_f = 1'b0, fb_f = 1'b0, ovp_f = 1'b0, flt_f = 1'b0, rel_f = 1'b0;
  logic          charge_en, gate_en, off_high;
  logic [CW-1:0] sink_code;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  ss_burst_seq #(.CHARGE_US(CHG), .STEP_US(STEP), .STEPS(NSTEP)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_1us     (tick),
    .supply_on_i  (on_f),
    .supply_off_i (off_f),
    .fb_burst_i   (fb_f),
    .ovp_i        (ovp_f),
    .fault_i      (flt_f),
    .release_i    (rel_f),
    .charge_en_o  (charge_en),
    .sink_code_o  (sink_code),
    .gate_en_o    (gate_en),
    .off_high_o   (off_high)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance n rising edges, end on the following falling edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    step(1);
    chk("R1 charge", charge_en, 0);
    chk("R1 code", sink_code, 0);
    chk("R1 gate", gate_en, 0);
    chk("R1 sel", off_high, 0);
    step(20);
    chk("R2 gate waits for on", gate_en, 0);
  endtask

  // enter soft start from startup, ending on the entry cycle
  task automatic enter_soft;
    on_f = 1'b1;
    step(2);
    chk("R2 sync latency charge", charge_en, 0);
    chk("R2 sync latency gate", gate_en, 0);
    step(1);
    chk("R3 charge at entry", charge_en, 1);
    chk("R4 code at entry", sink_code, NSTEP - 1);
    chk("R2 gate in soft", gate_en, 1);
    on_f = 1'b0;
  endtask

  task automatic t_staircase;
    enter_soft();
    tick = 1'b0;
    step(30);
    chk("R3 no tick no count charge", charge_en, 1);
    chk("R3 no tick no count code", sink_code, NSTEP - 1);
    tick = 1'b1;
    step(CHG - 1);
    chk("R3 charge last tick", charge_en, 1);
    step(1);
    chk("R3 charge off", charge_en, 0);
    step(STEP - CHG - 1);
    chk("R4 code before boundary", sink_code, NSTEP - 1);
    step(1);
    chk("R4 code after boundary", sink_code, NSTEP - 2);
    for (int k = 2; k < NSTEP; k++) begin
      step(STEP);
      chk("R4 staircase", sink_code, NSTEP - 1 - k);
    end
    step(STEP);
    chk("R5 code after end", sink_code, 0);
    chk("R5 gate after end", gate_en, 1);
    step(50);
    chk("R5 code stays 0", sink_code, 0);
    chk("R5 charge stays 0", charge_en, 0);
  endtask

  task automatic collapse;
    off_f = 1'b1;
    step(2);
    chk("R8 sync before collapse", gate_en | off_high, 1);
    step(1);
    chk("R8 sel normal", off_high, 0);
    chk("R8 gate off", gate_en, 0);
    off_f = 1'b0;
    step(3);
  endtask

  task automatic t_early_burst;
    collapse();
    fb_f = 1'b1;
    enter_soft();
    step(5);
    chk("R6 burst ignored early", gate_en, 1);
    step(CHG - 5);
    chk("R6 burst ignored at arm", gate_en, 1);
    step(1);
    chk("R7 gate blocked", gate_en, 0);
    chk("R7 sel high", off_high, 1);
    fb_f = 1'b0;
    step(10);
    chk("R7 burst holds", gate_en, 0);
    chk("R7 sel holds", off_high, 1);
    collapse();
    enter_soft();
    chk("R8 restart sel normal", off_high, 0);
    step(NSTEP * STEP);
    chk("R5 run reached", sink_code, 0);
  endtask

  task automatic t_run_burst;
    fb_f = 1'b1;
    step(2);
    chk("R7 run sync latency", gate_en, 1);
    step(1);
    chk("R7 run burst gate", gate_en, 0);
    chk("R7 run burst sel", off_high, 1);
    fb_f = 1'b0;
    collapse();
    enter_soft();
    step(NSTEP * STEP);
  endtask

  task automatic t_protect;
    chk("R9 gate before fault", gate_en, 1);
    ovp_f = 1'b1;
    step(1);
    ovp_f = 1'b0;
    step(2);
    chk("R9 ovp latches", gate_en, 0);
    step(20);
    chk("R9 latch holds", gate_en, 0);
    rel_f = 1'b1;
    step(3);
    chk("R10 release clears", gate_en, 1);
    flt_f = 1'b1;
    step(3);
    chk("R10 set wins over release", gate_en, 0);
    flt_f = 1'b0;
    step(4);
    chk("R10 clears after fault drops", gate_en, 1);
    rel_f = 1'b0;
    flt_f = 1'b1;
    step(3);
    flt_f = 1'b0;
    step(10);
    chk("R9 fault latch holds", gate_en, 0);
    rel_f = 1'b1;
    step(3);
    chk("R10 fault release", gate_en, 1);
    rel_f = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_staircase();
    t_early_burst();
    t_run_burst();
    t_protect();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule